// File: doc/BRIEF.md
# Sidetone Filter Coefficient Loader

This block holds the coefficient table and the two channel gains for a sidetone FIR filter, behind a small register interface. Software arms a load by raising a write-enable bit in the control word. It then streams 128 signed 16-bit coefficients into one data address, and the block places each one at an index it advances by itself. When the last entry lands, the block raises a done bit in the control word and marks the table valid for the filter. Software polls that bit and then drops write-enable.

A separate bit in the same control word switches the sidetone path on or off, whatever the state of the load. A gain word carries both channel gains, and one access writes them together. The filter reads coefficients through a tap-index port and sees the gains, the on bit and the table-valid flag as plain outputs.

Register map, selected by `busAddr`:
- 0, control. Bit 0 is sidetone on. Bit 1 is coefficient write-enable. Bit 2 is load done and is read-only.
- 1, coefficient data port. It is write-only and reads back as 0.
- 2, gain word.

Top module: `sidetone_coeff_loader`

## Requirements
- R1: After reset the control word reads 0, `tableValid` and `sidetoneOn` are 0, and both gains are 0.
- R2: A 0-to-1 change of write-enable (control bit 1) resets the load index to 0. The k-th data-port write after it (k counted from 1) is stored at tap k-1.
- R3: The done bit (control bit 2) reads 1 once the 128th coefficient has been stored, and not before.
- R4: Data-port writes after the 128th one are ignored: the stored taps keep their values and done stays 1.
- R5: Data-port writes while write-enable is 0 are ignored and leave the table unchanged.
- R6: The done bit clears when write-enable is written to 0, and also when a new load is armed.
- R7: Writing write-enable as 1 while it is already 1 does not restart the load, so the next write goes to the next index. Clearing and then setting it restarts at tap 0.
- R8: `tableValid` rises together with done. Arming a new load drops it, and it stays 0 through a partial load. Clearing write-enable after a full load leaves it at 1.
- R9: `sidetoneOn` follows control bit 0 on every control write and does not depend on the write-enable or done state.
- R10: One write to the gain word sets channel 0 gain from bits [15:0] and channel 1 gain from bits [31:16], both signed. The word reads back unchanged, and it holds its value until the next gain write.
- R11: Coefficients over the full signed 16-bit range, including -32768 and 32767, are returned unchanged on `tapCoeff`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 2 | Register select |
| busWData | input | 32 | Register write data |
| busRData | output | 32 | Register read data, combinational from `busAddr` |
| tapIdx | input | 7 | Coefficient index requested by the filter |
| tapCoeff | output | 16 | Signed coefficient at `tapIdx` |
| gainCh0 | output | 16 | Signed channel 0 gain |
| gainCh1 | output | 16 | Signed channel 1 gain |
| sidetoneOn | output | 1 | Sidetone path enable |
| tableValid | output | 1 | Table fully loaded and usable |

## Verification
The loader is driven with a full 128-word load, a run of surplus writes past the end, and stray writes while disarmed. It is also driven with a partial load cut short by a clear-and-set re-arm, and with a repeated set of write-enable that must not re-arm. A different value pattern for each load lets a tap read tell the current load apart from the previous one, and tells a restarted index from a continued one. The gain word is written with sign bits set in both halves, which shows whether the fields are swapped or truncated. The on bit is toggled on its own and also alongside arm and disarm writes.

// File: rtl/sidetone_pkg.sv
package sidetone_pkg;
  localparam int NUM_TAPS = 128;
  localparam int COEFF_W  = 16;
  localparam int IDX_W    = $clog2(NUM_TAPS + 1);
  localparam int TAP_W    = $clog2(NUM_TAPS);

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_COEFF = 2'd1;
  localparam logic [1:0] ADDR_GAIN  = 2'd2;

  localparam int BIT_ON   = 0;
  localparam int BIT_WE   = 1;
  localparam int BIT_DONE = 2;

  typedef struct packed {
    logic             coeffWr;
    logic [TAP_W-1:0] coeffIdx;
    logic             gainWr;
  } strobe_t;
endpackage

// File: rtl/sidetone_ctrl.sv
module sidetone_ctrl
  import sidetone_pkg::*;
#(
  parameter int TAPS = NUM_TAPS
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWr,
  input  logic [1:0] busAddr,
  input  logic [1:0] ctrlBits,
  output strobe_t    strb,
  output logic       sidetoneOn,
  output logic       tableValid,
  output logic [2:0] statusWord
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TAPS - 1);
  localparam logic [IDX_W-1:0] FULL_IDX = IDX_W'(TAPS);

  logic             weReg;
  logic             doneReg;
  logic [IDX_W-1:0] wrIdx;
  logic             ctrlWr, armEvt, disarmEvt, dataWr, lastWr;

  assign ctrlWr    = busWr && (busAddr == ADDR_CTRL);
  assign armEvt    = ctrlWr && ctrlBits[BIT_WE] && !weReg;
  assign disarmEvt = ctrlWr && !ctrlBits[BIT_WE];
  assign dataWr    = busWr && (busAddr == ADDR_COEFF) && weReg && (wrIdx < FULL_IDX);
  assign lastWr    = dataWr && (wrIdx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      weReg      <= 1'b0;
      doneReg    <= 1'b0;
      wrIdx      <= '0;
      sidetoneOn <= 1'b0;
      tableValid <= 1'b0;
    end else begin
      if (ctrlWr) begin
        sidetoneOn <= ctrlBits[BIT_ON];
        weReg      <= ctrlBits[BIT_WE];
      end
      if (armEvt) begin
        wrIdx      <= '0;
        doneReg    <= 1'b0;
        tableValid <= 1'b0;
      end else if (disarmEvt) begin
        doneReg <= 1'b0;
      end else if (dataWr) begin
        wrIdx <= wrIdx + 1'b1;
        if (lastWr) begin
          doneReg    <= 1'b1;
          tableValid <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    strb.coeffWr  = dataWr;
    strb.coeffIdx = wrIdx[TAP_W-1:0];
    strb.gainWr   = busWr && (busAddr == ADDR_GAIN);
    statusWord    = '0;
    statusWord[BIT_ON]   = sidetoneOn;
    statusWord[BIT_WE]   = weReg;
    statusWord[BIT_DONE] = doneReg;
  end

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rstN) wrIdx <= FULL_IDX); // R4
  AST_DONE_NEEDS_WE: assert property (@(posedge clk) disable iff (!rstN) doneReg |-> weReg); // R6
  AST_ARM_RESTART: assert property (@(posedge clk) disable iff (!rstN) $rose(weReg) |-> (wrIdx == '0 && !doneReg && !tableValid)); // R2
  AST_VALID_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN) $rose(doneReg) |-> tableValid); // R8
  AST_DONE_AT_FULL: assert property (@(posedge clk) disable iff (!rstN) $rose(doneReg) |-> wrIdx == FULL_IDX); // R3
endmodule

// File: rtl/sidetone_datapath.sv
module sidetone_datapath
  import sidetone_pkg::*;
#(
  parameter int TAPS = NUM_TAPS,
  parameter int CW   = COEFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [2*CW-1:0]   wData,
  input  logic [TAP_W-1:0]  tapIdx,
  output logic [CW-1:0]     tapCoeff,
  output logic [CW-1:0]     gainCh0,
  output logic [CW-1:0]     gainCh1,
  output logic [2*CW-1:0]   gainWord
);
  logic [CW-1:0]   coeffMem [TAPS];
  logic [2*CW-1:0] gainReg;

  always_ff @(posedge clk) begin
    if (strb.coeffWr) coeffMem[strb.coeffIdx] <= wData[CW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN)            gainReg <= '0;
    else if (strb.gainWr) gainReg <= wData;
  end

  assign tapCoeff = coeffMem[tapIdx];
  assign gainCh0  = gainReg[CW-1:0];
  assign gainCh1  = gainReg[2*CW-1:CW];
  assign gainWord = gainReg;

  AST_GAIN_HOLD: assert property (@(posedge clk) disable iff (!rstN) !strb.gainWr |=> $stable(gainReg)); // R10
  AST_TAP_STORE: assert property (@(posedge clk) disable iff (!rstN) strb.coeffWr |=> coeffMem[$past(strb.coeffIdx)] == $past(wData[CW-1:0])); // R2
endmodule

// File: rtl/sidetone_coeff_loader.sv
module sidetone_coeff_loader
  import sidetone_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWr,
  input  logic [1:0]         busAddr,
  input  logic [31:0]        busWData,
  output logic [31:0]        busRData,
  input  logic [TAP_W-1:0]   tapIdx,
  output logic [COEFF_W-1:0] tapCoeff,
  output logic [COEFF_W-1:0] gainCh0,
  output logic [COEFF_W-1:0] gainCh1,
  output logic               sidetoneOn,
  output logic               tableValid
);
  strobe_t             strb;
  logic [2:0]          statusWord;
  logic [2*COEFF_W-1:0] gainWord;

  sidetone_ctrl #(.TAPS(NUM_TAPS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busWr      (busWr),
    .busAddr    (busAddr),
    .ctrlBits   (busWData[1:0]),
    .strb       (strb),
    .sidetoneOn (sidetoneOn),
    .tableValid (tableValid),
    .statusWord (statusWord)
  );

  sidetone_datapath #(.TAPS(NUM_TAPS), .CW(COEFF_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wData    (busWData),
    .tapIdx   (tapIdx),
    .tapCoeff (tapCoeff),
    .gainCh0  (gainCh0),
    .gainCh1  (gainCh1),
    .gainWord (gainWord)
  );

  always_comb begin
    case (busAddr)
      ADDR_CTRL: busRData = {29'd0, statusWord};
      ADDR_GAIN: busRData = gainWord;
      default:   busRData = '0;
    endcase
  end
endmodule

// File: tb/sidetone_coeff_loader_bench.sv
module sidetone_coeff_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TAPS = 128;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [31:0] busWData = '0;
  logic [31:0] busRData;
  logic [6:0]  tapIdx = '0;
  logic [15:0] tapCoeff, gainCh0, gainCh1;
  logic        sidetoneOn, tableValid;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sidetone_coeff_loader u_sidetone_coeff_loader (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWData(busWData), .busRData(busRData), .tapIdx(tapIdx),
    .tapCoeff(tapCoeff), .gainCh0(gainCh0), .gainCh1(gainCh1),
    .sidetoneOn(sidetoneOn), .tableValid(tableValid)
  );

  function automatic logic [15:0] pat(int seed, int k);
    if (seed == 0 && k == 0)   return 16'h8000;
    if (seed == 0 && k == 127) return 16'h7FFF;
    return 16'((k * 613 + seed * 97) ^ 16'h2C5A);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWData = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic readCtrl(output logic [31:0] v);
    busAddr = 2'd0; #1; v = busRData;
  endtask

  task automatic readTap(int k, output logic [15:0] v);
    tapIdx = 7'(k); #1; v = tapCoeff;
  endtask

  task automatic loadWords(int seed, int first, int count);
    for (int k = first; k < first + count; k++) regWrite(2'd1, {16'd0, pat(seed, k)});
  endtask

  task automatic tableMatches(string tag, int seed, int first, int count);
    logic [15:0] v;
    int bad = 0;
    logic [15:0] firstAct = '0, firstExp = '0;
    for (int k = first; k < first + count; k++) begin
      readTap(k, v);
      if (v !== pat(seed, k) && bad == 0) begin firstAct = v; firstExp = pat(seed, k); end
      if (v !== pat(seed, k)) bad++;
    end
    check(tag, {16'd0, firstAct}, {16'd0, firstExp});
  endtask

  task automatic t_reset();
    logic [31:0] v;
    readCtrl(v);
    check("R1 ctrl", v, 32'd0);
    check("R1 valid/on", {30'd0, tableValid, sidetoneOn}, 32'd0);
    check("R1 gains", {gainCh1, gainCh0}, 32'd0);
  endtask

  task automatic t_full_load();
    logic [31:0] v;
    regWrite(2'd0, 32'h2);
    loadWords(0, 0, TAPS - 1);
    readCtrl(v);
    check("R3 done before last", {31'd0, v[2]}, 32'd0);
    check("R8 valid before last", {31'd0, tableValid}, 32'd0);
    loadWords(0, TAPS - 1, 1);
    readCtrl(v);
    check("R3 done after last", {31'd0, v[2]}, 32'd1);
    check("R8 valid with done", {31'd0, tableValid}, 32'd1);
    tableMatches("R2 table order", 0, 0, TAPS);
    readTap(0, v[15:0]);
    check("R11 min value", {16'd0, v[15:0]}, 32'h8000);
    readTap(127, v[15:0]);
    check("R11 max value", {16'd0, v[15:0]}, 32'h7FFF);
  endtask

  task automatic t_overrun();
    logic [31:0] v;
    regWrite(2'd1, 32'h1234);
    regWrite(2'd1, 32'h4321);
    tableMatches("R4 taps after overrun", 0, 0, TAPS);
    readCtrl(v);
    check("R4 done holds", {31'd0, v[2]}, 32'd1);
  endtask

  task automatic t_disarm();
    logic [31:0] v;
    regWrite(2'd0, 32'h0);
    readCtrl(v);
    check("R6 done clears on disarm", {31'd0, v[2]}, 32'd0);
    check("R8 valid kept after disarm", {31'd0, tableValid}, 32'd1);
  endtask

  task automatic t_idle_writes();
    logic [31:0] v;
    regWrite(2'd1, 32'h0BAD);
    regWrite(2'd1, 32'h0BEE);
    tableMatches("R5 idle writes ignored", 0, 0, TAPS);
    readCtrl(v);
    check("R5 ctrl idle", {29'd0, v[2:0]}, 32'd0);
  endtask

  task automatic t_rearm();
    logic [31:0] v;
    logic [15:0] t;
    regWrite(2'd0, 32'h2);
    loadWords(0, TAPS - 1, 1);
    readCtrl(v);
    check("R7 no restart at full", {31'd0, v[2]}, 32'd0);
    regWrite(2'd0, 32'h2);
    regWrite(2'd0, 32'h0);
    regWrite(2'd0, 32'h2);
    loadWords(1, 0, 5);
    check("R8 partial keeps invalid", {31'd0, tableValid}, 32'd0);
    tableMatches("R7 restart at tap 0", 1, 0, 5);
    regWrite(2'd0, 32'h2);
    loadWords(1, 5, 1);
    readTap(5, t);
    check("R7 repeat set continues", {16'd0, t}, {16'd0, pat(1, 5)});
    loadWords(1, 6, TAPS - 6);
    readCtrl(v);
    check("R3 second load done", {31'd0, v[2]}, 32'd1);
    check("R8 second load valid", {31'd0, tableValid}, 32'd1);
    regWrite(2'd0, 32'h0);
    regWrite(2'd0, 32'h2);
    readCtrl(v);
    check("R6 done clears on arm", {31'd0, v[2]}, 32'd0);
    check("R8 arm drops valid", {31'd0, tableValid}, 32'd0);
    regWrite(2'd0, 32'h0);
  endtask

  task automatic t_sidetone();
    logic [31:0] v;
    regWrite(2'd0, 32'h1);
    check("R9 on alone", {31'd0, sidetoneOn}, 32'd1);
    regWrite(2'd0, 32'h3);
    check("R9 on while arming", {31'd0, sidetoneOn}, 32'd1);
    readCtrl(v);
    check("R9 ctrl readback", {29'd0, v[2:0]}, 32'd3);
    regWrite(2'd0, 32'h2);
    check("R9 off while armed", {31'd0, sidetoneOn}, 32'd0);
    regWrite(2'd0, 32'h0);
  endtask

  task automatic t_gain();
    logic [31:0] v;
    regWrite(2'd2, 32'hF00D_8001);
    check("R10 ch0", {16'd0, gainCh0}, 32'h8001);
    check("R10 ch1", {16'd0, gainCh1}, 32'hF00D);
    busAddr = 2'd2; #1; v = busRData;
    check("R10 readback", v, 32'hF00D_8001);
    regWrite(2'd0, 32'h1);
    check("R10 gain holds", {gainCh1, gainCh0}, 32'hF00D_8001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_load();
    t_overrun();
    t_disarm();
    t_idle_writes();
    t_rearm();
    t_sidetone();
    t_gain();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule